// File: doc/BRIEF.md
# Blit Paste Coordinate Transformer

This block sits between the pixel fetch and the pixel write stages of a rectangle copy engine. It accepts the colours of a source rectangle one pixel at a time, in raster order, and turns each one into zero or more destination write requests. Each request carries a destination X/Y and the colour to store. Along the way it applies integer enlargement, fractional shrinking, a colour-key mask, a horizontal mirror, a vertical flip, a quarter-turn rotation, a diagonal 45-degree step and centring about the paste point. Any request that lands outside the destination surface is discarded.

The pixel stream and the write stream each use a valid/ready handshake. A one-cycle `start` pulse before each rectangle clears the position tracking. The configuration inputs are held constant for the whole rectangle. Memory addressing and pixel storage belong to neighbouring blocks.

Top module: `blit_paste_xform`

## Requirements
- R1: After reset, `dst_valid` is low and `src_ready` is high.
- R2: With `mode[0]` (enable) low, every source pixel (sx,sy) gives exactly one write at (paste_x+sx, paste_y+sy) with its own colour. All other mode bits and all zoom factors are ignored.
- R3: With the block enabled and `mode[7]` (mask) set, a pixel whose colour equals `key_color` gives no write. With `mode[7]` clear, colour plays no part.
- R4: Each retained source pixel expands to a block of ux by uy writes, where ux=`up_x` and uy=`up_y` and a code of 0 means 1. Within the block the X replica index runs fastest. The last column and row get full-size blocks like every other pixel.
- R5: Shrinking per axis uses the factor d/4096, with d=`dn_x` or `dn_y` and 0 meaning no shrink. Along an axis, a 12-bit residue starts at 0. A pixel is kept when residue < d, and the residue then advances by d modulo 4096. This means the first column and row are always kept.
- R6: The scaled offset (ox,oy) of a write is (kept-index·ux + replica, ...) inside an extent (EX,EY). `mode[3]` replaces ox by EX-1-ox, and `mode[4]` replaces oy by EY-1-oy.
- R7: `mode[1]` rotates a quarter turn clockwise: (ox,oy) becomes (EY-1-oy, ox). This is applied after mirror and flip, and the extents swap.
- R8: `mode[2]` then maps (u,v) to (u-v, u+v), so a step along source X moves both destination axes together.
- R9: `mode[5]` subtracts half the post-rotation X extent (rounded down) from X, and `mode[6]` does the same for Y. The paste origin is then added.
- R10: A write whose X is outside 0..dst_w-1 or whose Y is outside 0..dst_h-1 is never presented, and it costs one cycle without waiting on `dst_ready`.
- R11: While `dst_valid` is high and `dst_ready` is low, `dst_valid`, `dst_x`, `dst_y` and `dst_color` hold steady. Each accepted transfer is one write.
- R12: `src_ready` is low whenever a write is being presented.
- R13: A `start` pulse abandons a partly sent rectangle, so the next pixel is treated as source (0,0) with cleared residues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Clears position tracking before a rectangle |
| mode | input | 8 | Bit 0 enable, 1 quarter turn, 2 diagonal, 3 mirror, 4 flip, 5 centre X, 6 centre Y, 7 mask |
| blit_w | input | CW | Source rectangle width in pixels (nonzero) |
| blit_h | input | CW | Source rectangle height in pixels (nonzero) |
| paste_x | input | CW | Destination paste X |
| paste_y | input | CW | Destination paste Y |
| dst_w | input | CW | Destination surface width |
| dst_h | input | CW | Destination surface height |
| up_x | input | CW | Integer X enlargement (0 = 1) |
| up_y | input | CW | Integer Y enlargement (0 = 1) |
| dn_x | input | CW | X shrink numerator over 4096 (0 = none) |
| dn_y | input | CW | Y shrink numerator over 4096 (0 = none) |
| key_color | input | PW | Transparent colour |
| src_valid | input | 1 | Source pixel present |
| src_color | input | PW | Source pixel colour |
| src_ready | output | 1 | Source pixel accepted when high with valid |
| dst_valid | output | 1 | Write request present |
| dst_ready | input | 1 | Write request taken |
| dst_x | output | CW | Write X |
| dst_y | output | CW | Write Y |
| dst_color | output | PW | Write colour |

## Verification
The properties assume that `mode`, the geometry inputs, the zoom factors and `key_color` stay unchanged from the `start` pulse until the last write of the rectangle has been taken, and that both rectangle dimensions are nonzero. Holding and single-write checks depend on this, because the outputs are combinational in those inputs. The stimulus honours it by changing the configuration only after `src_ready` has returned high following the final pixel. `start` is pulsed only while no write is pending, and `dst_ready` is only throttled during rectangles whose settings are frozen.

// File: rtl/blit_paste_xform.sv
module blit_paste_xform #(
  parameter int CW = 12,
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [7:0]    mode,
  input  logic [CW-1:0] blit_w,
  input  logic [CW-1:0] blit_h,
  input  logic [CW-1:0] paste_x,
  input  logic [CW-1:0] paste_y,
  input  logic [CW-1:0] dst_w,
  input  logic [CW-1:0] dst_h,
  input  logic [CW-1:0] up_x,
  input  logic [CW-1:0] up_y,
  input  logic [CW-1:0] dn_x,
  input  logic [CW-1:0] dn_y,
  input  logic [PW-1:0] key_color,
  input  logic          src_valid,
  input  logic [PW-1:0] src_color,
  output logic          src_ready,
  output logic          dst_valid,
  input  logic          dst_ready,
  output logic [CW-1:0] dst_x,
  output logic [CW-1:0] dst_y,
  output logic [PW-1:0] dst_color
);
  localparam int XW = 2*CW;
  localparam int SW = 2*CW + 3;
  localparam logic [CW:0] FULL = {1'b1, {CW{1'b0}}};

  logic en, f_r90, f_r45, f_mir, f_flp, f_hc, f_vc, f_key;
  assign en    = mode[0];
  assign f_r90 = en & mode[1];
  assign f_r45 = en & mode[2];
  assign f_mir = en & mode[3];
  assign f_flp = en & mode[4];
  assign f_hc  = en & mode[5];
  assign f_vc  = en & mode[6];
  assign f_key = en & mode[7];

  logic [CW-1:0] ux, uy;
  logic [CW:0]   dx, dy;
  assign ux = (!en || up_x == '0) ? CW'(1) : up_x;
  assign uy = (!en || up_y == '0) ? CW'(1) : up_y;
  assign dx = (!en || dn_x == '0) ? FULL : {1'b0, dn_x};
  assign dy = (!en || dn_y == '0) ? FULL : {1'b0, dn_y};

  logic [XW:0]   prod_x, prod_y;
  logic [XW-1:0] ext_x, ext_y;
  assign prod_x = (XW+1)'(blit_w) * (XW+1)'(dx) + (XW+1)'({CW{1'b1}});
  assign prod_y = (XW+1)'(blit_h) * (XW+1)'(dy) + (XW+1)'({CW{1'b1}});
  assign ext_x  = XW'(prod_x[CW +: CW]) * XW'(ux);
  assign ext_y  = XW'(prod_y[CW +: CW]) * XW'(uy);

  logic [CW-1:0] sx, sy, ax, ay, kx, ky, rx, ry;
  logic [XW-1:0] bx, by;
  logic [PW-1:0] col;
  logic          busy;

  logic take, row_end, last_row, keep_x, keep_y, go, in_b, step;
  assign src_ready = !busy;
  assign take      = src_valid && !busy && !start;
  assign keep_x    = dx[CW] || ({1'b0, ax} < dx);
  assign keep_y    = dy[CW] || ({1'b0, ay} < dy);
  assign row_end   = (sx == blit_w - CW'(1));
  assign last_row  = (sy == blit_h - CW'(1));
  assign go        = keep_x && keep_y && !(f_key && src_color == key_color);
  assign step      = !in_b || dst_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sx <= '0; sy <= '0; ax <= '0; ay <= '0; kx <= '0; ky <= '0;
      rx <= '0; ry <= '0; bx <= '0; by <= '0; col <= '0; busy <= 1'b0;
    end else if (start) begin
      sx <= '0; sy <= '0; ax <= '0; ay <= '0; kx <= '0; ky <= '0;
      rx <= '0; ry <= '0; busy <= 1'b0;
    end else if (take) begin
      if (row_end) begin
        sx <= '0; ax <= '0; kx <= '0;
        if (last_row) begin
          sy <= '0; ay <= '0; ky <= '0;
        end else begin
          sy <= sy + CW'(1);
          ay <= ay + dy[CW-1:0];
          ky <= ky + CW'(keep_y);
        end
      end else begin
        sx <= sx + CW'(1);
        ax <= ax + dx[CW-1:0];
        kx <= kx + CW'(keep_x);
      end
      if (go) begin
        busy <= 1'b1;
        rx   <= '0;
        ry   <= '0;
        bx   <= XW'(kx) * XW'(ux);
        by   <= XW'(ky) * XW'(uy);
        col  <= src_color;
      end
    end else if (busy && step) begin
      if (rx == ux - CW'(1)) begin
        rx <= '0;
        if (ry == uy - CW'(1)) busy <= 1'b0;
        else ry <= ry + CW'(1);
      end else begin
        rx <= rx + CW'(1);
      end
    end
  end

  logic signed [SW-1:0] ox, oy, ex, ey, mx, my, u1, v1, ex2, ey2, u2, v2, px, py;
  assign ox  = SW'(bx) + SW'(rx);
  assign oy  = SW'(by) + SW'(ry);
  assign ex  = SW'(ext_x);
  assign ey  = SW'(ext_y);
  assign mx  = f_mir ? ex - ox - SW'(1) : ox;
  assign my  = f_flp ? ey - oy - SW'(1) : oy;
  assign u1  = f_r90 ? ey - my - SW'(1) : mx;
  assign v1  = f_r90 ? mx : my;
  assign ex2 = f_r90 ? ey : ex;
  assign ey2 = f_r90 ? ex : ey;
  assign u2  = f_r45 ? u1 - v1 : u1;
  assign v2  = f_r45 ? u1 + v1 : v1;
  assign px  = SW'(paste_x) + u2 - (f_hc ? (ex2 >>> 1) : SW'(0));
  assign py  = SW'(paste_y) + v2 - (f_vc ? (ey2 >>> 1) : SW'(0));

  assign in_b = !px[SW-1] && !py[SW-1]
             && (px[SW-2:0] < (SW-1)'(dst_w))
             && (py[SW-2:0] < (SW-1)'(dst_h));

  assign dst_valid = busy && in_b;
  assign dst_x     = px[CW-1:0];
  assign dst_y     = py[CW-1:0];
  assign dst_color = col;

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    dst_valid && !dst_ready && !start |=>
      dst_valid && $stable(dst_x) && $stable(dst_y) && $stable(dst_color));

  p_bounds_r10: assert property (@(posedge clk) disable iff (!rst_n)
    dst_valid |-> (dst_x < dst_w) && (dst_y < dst_h));

  p_masked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    src_valid && src_ready && !start && mode[0] && mode[7] && src_color == key_color
      |=> src_ready && !dst_valid);

  p_exclusive_r12: assert property (@(posedge clk) disable iff (!rst_n)
    dst_valid |-> !src_ready);

  p_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !mode[0] && !start && dst_valid && dst_ready |=> src_ready);
endmodule

// File: tb/tb_blit_paste_xform.sv
module tb_blit_paste_xform;
  localparam int CW = 12, PW = 8, MAXW = 2048;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [7:0] mode = 8'h00;
  logic [CW-1:0] blit_w = 5, blit_h = 4, paste_x = 20, paste_y = 10;
  logic [CW-1:0] dst_w = 64, dst_h = 64, up_x = 0, up_y = 0, dn_x = 0, dn_y = 0;
  logic [PW-1:0] key_color = 0, src_color = 0;
  logic src_valid = 1'b0, dst_ready = 1'b1;
  logic src_ready, dst_valid;
  logic [CW-1:0] dst_x, dst_y;
  logic [PW-1:0] dst_color;

  int checks = 0, fails = 0, ngot = 0, nexp = 0, cyc = 0;
  int gx[MAXW], gy[MAXW], gc[MAXW], qx[MAXW], qy[MAXW], qc[MAXW];
  bit stall = 0;

  blit_paste_xform #(.CW(CW), .PW(PW)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
    .blit_w(blit_w), .blit_h(blit_h), .paste_x(paste_x), .paste_y(paste_y),
    .dst_w(dst_w), .dst_h(dst_h), .up_x(up_x), .up_y(up_y), .dn_x(dn_x), .dn_y(dn_y),
    .key_color(key_color), .src_valid(src_valid), .src_color(src_color),
    .src_ready(src_ready), .dst_valid(dst_valid), .dst_ready(dst_ready),
    .dst_x(dst_x), .dst_y(dst_y), .dst_color(dst_color));

  always #2 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    dst_ready <= !stall || (cyc % 3 != 0);
  end

  logic hold_pend = 1'b0;
  logic [CW-1:0] hx, hy;
  logic [PW-1:0] hcol;
  always @(negedge clk) if (rst_n) begin
    if (hold_pend) begin
      checks++;
      if (!dst_valid || dst_x != hx || dst_y != hy || dst_color != hcol) begin
        fails++;
        $display("FAIL R11 held request changed: got v=%0d (%0d,%0d,%0d) exp (%0d,%0d,%0d)",
                 dst_valid, dst_x, dst_y, dst_color, hx, hy, hcol);
      end
    end
    if (dst_valid) begin
      checks++;
      if (src_ready) begin
        fails++;
        $display("FAIL R12 src_ready got 1 exp 0 while writing");
      end
    end
    hold_pend = dst_valid && !dst_ready;
    hx = dst_x; hy = dst_y; hcol = dst_color;
    if (dst_valid && dst_ready) begin
      if (ngot < MAXW) begin
        gx[ngot] = dst_x; gy[ngot] = dst_y; gc[ngot] = dst_color;
      end
      ngot++;
    end
  end

  function automatic int pix(int sx, int sy);
    return (sx*37 + sy*11 + 5) & 255;
  endfunction

  task automatic model();
    int ux, uy, dx, dy, ex, ey, ex2, ey2, ax, ay, kx, ky;
    int ox, oy, mx, my, u, v, u2, v2, xx, yy, c;
    bit en, r90, r45, mir, flp, hc, vc, msk, kpx, kpy;
    en = mode[0]; r90 = en && mode[1]; r45 = en && mode[2]; mir = en && mode[3];
    flp = en && mode[4]; hc = en && mode[5]; vc = en && mode[6]; msk = en && mode[7];
    ux = (!en || up_x == 0) ? 1 : int'(up_x);
    uy = (!en || up_y == 0) ? 1 : int'(up_y);
    dx = (!en || dn_x == 0) ? 4096 : int'(dn_x);
    dy = (!en || dn_y == 0) ? 4096 : int'(dn_y);
    ex = ((int'(blit_w)*dx + 4095) / 4096) * ux;
    ey = ((int'(blit_h)*dy + 4095) / 4096) * uy;
    ex2 = r90 ? ey : ex;
    ey2 = r90 ? ex : ey;
    nexp = 0; ay = 0; ky = 0;
    for (int sy = 0; sy < int'(blit_h); sy++) begin
      kpy = (dy == 4096) || (ay < dy);
      ax = 0; kx = 0;
      for (int sx = 0; sx < int'(blit_w); sx++) begin
        kpx = (dx == 4096) || (ax < dx);
        c = pix(sx, sy);
        if (kpx && kpy && !(msk && c == int'(key_color)))
          for (int ry = 0; ry < uy; ry++)
            for (int rx = 0; rx < ux; rx++) begin
              ox = kx*ux + rx; oy = ky*uy + ry;
              mx = mir ? ex - 1 - ox : ox;
              my = flp ? ey - 1 - oy : oy;
              u  = r90 ? ey - 1 - my : mx;
              v  = r90 ? mx : my;
              u2 = r45 ? u - v : u;
              v2 = r45 ? u + v : v;
              xx = int'(paste_x) + u2 - (hc ? ex2/2 : 0);
              yy = int'(paste_y) + v2 - (vc ? ey2/2 : 0);
              if (xx >= 0 && xx < int'(dst_w) && yy >= 0 && yy < int'(dst_h) && nexp < MAXW) begin
                qx[nexp] = xx; qy[nexp] = yy; qc[nexp] = c; nexp++;
              end
            end
        if (kpx) kx++;
        ax = (ax + dx) % 4096;
      end
      if (kpy) ky++;
      ay = (ay + dy) % 4096;
    end
  endtask

  task automatic send_px(input int c);
    src_valid = 1'b1; src_color = PW'(c);
    while (!src_ready) @(negedge clk);
    @(negedge clk);
    src_valid = 1'b0;
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1; ngot = 0;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic finish_and_compare(input string tag);
    while (!src_ready) @(negedge clk);
    repeat (2) @(negedge clk);
    model();
    checks++;
    if (ngot != nexp) begin
      fails++;
      $display("FAIL %s write count got %0d exp %0d", tag, ngot, nexp);
    end
    for (int i = 0; i < nexp && i < ngot; i++) begin
      checks++;
      if (gx[i] != qx[i] || gy[i] != qy[i] || gc[i] != qc[i]) begin
        fails++;
        $display("FAIL %s write %0d got (%0d,%0d,%0d) exp (%0d,%0d,%0d)",
                 tag, i, gx[i], gy[i], gc[i], qx[i], qy[i], qc[i]);
      end
    end
  endtask

  task automatic run_blit(input string tag);
    pulse_start();
    for (int sy = 0; sy < int'(blit_h); sy++)
      for (int sx = 0; sx < int'(blit_w); sx++) send_px(pix(sx, sy));
    finish_and_compare(tag);
  endtask

  task automatic setup(input logic [7:0] m, input int ux, input int uy, input int dx, input int dy,
                       input int w, input int h, input int pxx, input int pyy);
    mode = m; up_x = CW'(ux); up_y = CW'(uy); dn_x = CW'(dx); dn_y = CW'(dy);
    blit_w = CW'(w); blit_h = CW'(h); paste_x = CW'(pxx); paste_y = CW'(pyy);
  endtask

  task automatic t_reset();
    @(negedge clk);
    checks++;
    if (dst_valid !== 1'b0 || src_ready !== 1'b1) begin
      fails++;
      $display("FAIL R1 after reset got v=%0d r=%0d exp v=0 r=1", dst_valid, src_ready);
    end
  endtask

  task automatic t_passthrough();
    key_color = PW'(pix(2, 1));
    setup(8'b1000_1010, 3, 2, 2048, 2048, 5, 4, 20, 10);
    run_blit("R2");
    checks++;
    if (ngot != 20) begin fails++; $display("FAIL R2 count got %0d exp 20", ngot); end
  endtask

  task automatic t_mask();
    key_color = PW'(pix(2, 1));
    setup(8'h81, 0, 0, 0, 0, 5, 4, 20, 10);
    run_blit("R3 mask on");
    checks++;
    if (ngot != 19) begin fails++; $display("FAIL R3 masked count got %0d exp 19", ngot); end
    setup(8'h01, 0, 0, 0, 0, 5, 4, 20, 10);
    run_blit("R3 mask off");
  endtask

  task automatic t_up();
    setup(8'h01, 3, 2, 0, 0, 5, 4, 20, 10);
    run_blit("R4");
    checks++;
    if (ngot != 120) begin fails++; $display("FAIL R4 count got %0d exp 120", ngot); end
  endtask

  task automatic t_down();
    setup(8'h01, 0, 0, 2048, 1365, 6, 6, 20, 10);
    run_blit("R5");
    checks++;
    if (ngot < 1 || gx[0] != 20 || gy[0] != 10 || gc[0] != pix(0, 0)) begin
      fails++; $display("FAIL R5 first write got (%0d,%0d,%0d) exp (20,10,%0d)", gx[0], gy[0], gc[0], pix(0, 0));
    end
    setup(8'h01, 2, 3, 1024, 3000, 7, 5, 5, 5);
    run_blit("R5 mixed");
  endtask

  task automatic t_orient();
    setup(8'h19, 0, 0, 0, 0, 5, 4, 20, 10);
    run_blit("R6");
    setup(8'h0B, 2, 1, 0, 0, 5, 4, 20, 10);
    run_blit("R7");
    setup(8'h13, 1, 2, 0, 0, 4, 3, 20, 10);
    run_blit("R7 flip");
    setup(8'h05, 0, 0, 0, 0, 5, 4, 30, 10);
    run_blit("R8");
    setup(8'h61, 2, 2, 0, 0, 5, 4, 20, 20);
    run_blit("R9");
  endtask

  task automatic t_bounds();
    setup(8'h61, 2, 2, 0, 0, 5, 4, 1, 62);
    run_blit("R10");
    checks++;
    if (ngot >= 80) begin fails++; $display("FAIL R10 count got %0d exp below 80", ngot); end
  endtask

  task automatic t_stall();
    setup(8'h0B, 2, 2, 0, 0, 5, 4, 20, 10);
    stall = 1;
    run_blit("R11");
    stall = 0;
  endtask

  task automatic t_restart();
    setup(8'h01, 0, 0, 2048, 2048, 6, 4, 20, 10);
    pulse_start();
    for (int i = 0; i < 3; i++) send_px(200);
    while (!src_ready) @(negedge clk);
    run_blit("R13");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog run did not finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_passthrough();
    t_mask();
    t_up();
    t_down();
    t_orient();
    t_bounds();
    t_stall();
    t_restart();
    repeat (4) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule